// File: doc/BRIEF.md
# Triple-Redundant Stroke Watchdog

This block supervises three redundant processors that each toggle a stroke line at a steady rate. A processor that produces no rising edge on its stroke line for longer than a silence limit is counted as down. A single down processor is tolerated for a long grace period, long enough for that unit to be reloaded and brought back into lock-step with the other two. When two or more processors are down at once, the grace period is short. When the active grace period runs out, a single error line goes high and stays high until reset. A later stage uses that line to shut the module down.

Each stroke line is asynchronous to the clock. It passes through a two-flop synchroniser and a rising-edge detector. Each edge restarts that processor's silence counter. The count of down processors drives a four-state controller:

- `ST_ALL_OK`: no processor is down.
- `ST_ONE_DOWN`: exactly one processor is down; the long timer runs.
- `ST_MULTI_DOWN`: two or more processors are down; the short timer runs.
- `ST_TRIPPED`: terminal state, error high.

The controller moves between these states as follows:

| Transition | Taken when | Timer |
|---|---|---|
| ALL_OK to ONE_DOWN | one processor is down | cleared |
| ALL_OK to MULTI_DOWN | two or more are down | cleared |
| ONE_DOWN to MULTI_DOWN | the down count rises to two or more | restarted |
| MULTI_DOWN to ONE_DOWN | the down count falls to one | restarted |
| ONE_DOWN to ALL_OK | every processor is back | discarded |
| MULTI_DOWN to ALL_OK | every processor is back | discarded |
| ONE_DOWN to TRIPPED | the long timer expires | not used |
| MULTI_DOWN to TRIPPED | the short timer expires | not used |

Top module: `tmr_stroke_watchdog`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `err_out` is 0 and the controller is in `ST_ALL_OK`.
- R2: While every processor produces a rising stroke edge at least once every `SILENCE_TICKS` cycles, `err_out` stays 0.
- R3: A rising edge on `stroke[i]` clears processor i's silence counter. The edge reaches the counter two cycles after the input changes, through the synchroniser. Processor i counts as down once its counter reaches `SILENCE_TICKS`.
- R4: If exactly one processor is down and stays down, the controller enters `ST_ONE_DOWN` one cycle after the processor becomes down. `err_out` rises `SINGLE_TICKS` cycles after that entry. For example, with one line silent from reset, `err_out` first reads 1 after clock edge `SILENCE_TICKS + SINGLE_TICKS + 1`.
- R5: If two or more processors are down, `err_out` rises `MULTI_TICKS` cycles after the controller enters `ST_MULTI_DOWN`. For example, with two or three lines silent from reset, `err_out` first reads 1 after clock edge `SILENCE_TICKS + MULTI_TICKS + 1`.
- R6: If a second processor goes down while the controller is in `ST_ONE_DOWN`, the short timer applies, restarted from zero. The error then fires well before the long limit would have expired.
- R7: If every down processor resumes stroking before its limit expires, the controller returns to `ST_ALL_OK`, the elapsed time is discarded, and `err_out` stays 0.
- R8: Once `err_out` is 1, it stays 1 until reset, whatever the stroke lines do.
- R9: Only rising edges count as strokes. A line held constantly high is treated the same as a silent line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stroke | input | N_PROC | Asynchronous stroke lines, one per processor |
| err_out | output | 1 | Watchdog error, sticky until reset |

## Verification
Each result is due at a fixed clock edge counted from reset release. A processor that is silent from reset becomes down after edge `SILENCE_TICKS`. The controller changes state one edge later. `err_out` rises after the chosen limit has elapsed on top of that, at edge S+L+1, where S is `SILENCE_TICKS` and L is the active limit. A line held high adds a three-edge offset, because its single synchronised edge clears the counter at edge 3. The driver places each expected value in a queue tagged with its edge number, one edge before and one edge after every trip, so an off-by-one in any stage is caught. The monitor pops each item at the falling clock edge following that numbered rising edge. Cases whose timing depends on where the stroke phase falls (escalation, recovery) are checked only at edges safely clear of the possible window.

// File: rtl/wdm_pkg.sv
package wdm_pkg;
    typedef enum logic [1:0] {
        ST_ALL_OK     = 2'd0,
        ST_ONE_DOWN   = 2'd1,
        ST_MULTI_DOWN = 2'd2,
        ST_TRIPPED    = 2'd3
    } wdm_state_e;
endpackage

// File: rtl/wdm_stroke_edge.sv
// Two-flop synchroniser followed by a rising-edge detector.
module wdm_stroke_edge (
    input  logic clk,
    input  logic rst,
    input  logic stroke_async,
    output logic rise_pulse
);
    logic meta_q, sync_q, last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= stroke_async;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    always_comb rise_pulse = sync_q & ~last_q;
endmodule

// File: rtl/wdm_silence_timer.sv
// Counts cycles since the last stroke; saturates at the silence limit.
module wdm_silence_timer #(
    parameter int unsigned SILENCE_TICKS = 300_000
) (
    input  logic clk,
    input  logic rst,
    input  logic rise_pulse,
    output logic is_down
);
    localparam int CW = $clog2(SILENCE_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(SILENCE_TICKS);

    logic [CW-1:0] quiet_q;

    always_ff @(posedge clk) begin
        if (rst || rise_pulse) begin
            quiet_q <= '0;
        end else if (quiet_q != LIMIT) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    always_comb is_down = (quiet_q == LIMIT);
endmodule

// File: rtl/wdm_vote_fsm.sv
// Picks the grace period from the number of down processors and trips.
module wdm_vote_fsm
    import wdm_pkg::*;
#(
    parameter int unsigned N_PROC       = 3,
    parameter int unsigned SINGLE_TICKS = 600_000_000,
    parameter int unsigned MULTI_TICKS  = 2_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PROC-1:0] down_vec,
    output logic              trip
);
    localparam int TW = $clog2(SINGLE_TICKS + 1);
    localparam int NW = $clog2(N_PROC + 1);
    localparam logic [TW-1:0] SINGLE_LAST = TW'(SINGLE_TICKS - 1);
    localparam logic [TW-1:0] MULTI_LAST  = TW'(MULTI_TICKS - 1);
    localparam logic [NW-1:0] CNT_ZERO    = '0;
    localparam logic [NW-1:0] CNT_ONE     = NW'(1);

    wdm_state_e    state_q, state_d;
    logic [TW-1:0] tmr_q, tmr_d;
    logic [NW-1:0] n_down;

    always_comb begin
        n_down = '0;
        for (int i = 0; i < int'(N_PROC); i++) begin
            n_down = n_down + NW'(down_vec[i]);
        end
    end

    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q + 1'b1;
        unique case (state_q)
            ST_ALL_OK: begin
                tmr_d = '0;
                if (n_down > CNT_ONE)       state_d = ST_MULTI_DOWN;
                else if (n_down == CNT_ONE) state_d = ST_ONE_DOWN;
            end
            ST_ONE_DOWN: begin
                if (n_down == CNT_ZERO) begin
                    state_d = ST_ALL_OK;
                    tmr_d   = '0;
                end else if (n_down > CNT_ONE) begin
                    state_d = ST_MULTI_DOWN;
                    tmr_d   = '0;
                end else if (tmr_q == SINGLE_LAST) begin
                    state_d = ST_TRIPPED;
                end
            end
            ST_MULTI_DOWN: begin
                if (n_down == CNT_ZERO) begin
                    state_d = ST_ALL_OK;
                    tmr_d   = '0;
                end else if (n_down == CNT_ONE) begin
                    state_d = ST_ONE_DOWN;
                    tmr_d   = '0;
                end else if (tmr_q == MULTI_LAST) begin
                    state_d = ST_TRIPPED;
                end
            end
            ST_TRIPPED: begin
                tmr_d = tmr_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ALL_OK;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
        end
    end

    always_comb trip = (state_q == ST_TRIPPED);
endmodule

// File: rtl/tmr_stroke_watchdog.sv
module tmr_stroke_watchdog #(
    parameter int unsigned N_PROC        = 3,
    parameter int unsigned SILENCE_TICKS = 300_000,
    parameter int unsigned SINGLE_TICKS  = 600_000_000,
    parameter int unsigned MULTI_TICKS   = 2_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PROC-1:0] stroke,
    output logic              err_out
);
    logic [N_PROC-1:0] pulse_v;
    logic [N_PROC-1:0] down_v;

    for (genvar g = 0; g < int'(N_PROC); g++) begin : g_proc
        wdm_stroke_edge u_edge (
            .clk          (clk),
            .rst          (rst),
            .stroke_async (stroke[g]),
            .rise_pulse   (pulse_v[g])
        );
        wdm_silence_timer #(.SILENCE_TICKS(SILENCE_TICKS)) u_quiet (
            .clk        (clk),
            .rst        (rst),
            .rise_pulse (pulse_v[g]),
            .is_down    (down_v[g])
        );
    end

    wdm_vote_fsm #(
        .N_PROC       (N_PROC),
        .SINGLE_TICKS (SINGLE_TICKS),
        .MULTI_TICKS  (MULTI_TICKS)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .down_vec (down_v),
        .trip     (err_out)
    );
endmodule

// File: rtl/wdm_checker.sv
module wdm_checker #(
    parameter int unsigned N_PROC = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              err,
    input logic [N_PROC-1:0] down,
    input logic [N_PROC-1:0] pulse
);
    assert_reset_low_R1: assert property (@(posedge clk) rst |=> !err);

    assert_alive_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (down == '0 && !err) |=> !err);

    assert_edge_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (pulse != '0) |=> ((down & $past(pulse)) == '0));

    assert_trip_needs_down_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> $past(down != '0));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        err |=> err);
endmodule

bind tmr_stroke_watchdog wdm_checker #(.N_PROC(N_PROC)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .err   (err_out),
    .down  (down_v),
    .pulse (pulse_v)
);

// File: tb/sim_tmr_stroke_watchdog.sv
`timescale 1ns/1ps
module sim_tmr_stroke_watchdog;
    localparam int SIL    = 20;
    localparam int SINGLE = 200;
    localparam int MULTI  = 30;
    localparam int PERIOD = 10;

    typedef struct {
        int    cyc;
        bit    val;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] stroke = '0;
    logic       err_out;

    logic [2:0] en   = '0;
    logic [2:0] hold = '0;
    int         cyc = 0;
    int         ph  = 0;
    int         n_checks = 0;
    int         n_errors = 0;
    bit         done = 1'b0;
    exp_t       sb_q[$];

    always #5 clk = ~clk;

    tmr_stroke_watchdog #(
        .N_PROC(3), .SILENCE_TICKS(SIL), .SINGLE_TICKS(SINGLE), .MULTI_TICKS(MULTI)
    ) u0 (
        .clk(clk), .rst(rst), .stroke(stroke), .err_out(err_out)
    );

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    // stroke generator: 3-cycle high pulse every PERIOD cycles on enabled lines
    initial begin
        forever begin
            @(negedge clk);
            ph = (ph + 1) % PERIOD;
            for (int i = 0; i < 3; i++)
                stroke[i] = hold[i] | (en[i] & (ph < 3));
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    task automatic expect_at(input int c, input bit v, input string tag);
        exp_t e;
        e.cyc = c; e.val = v; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor: compares queued expectations at the falling edge of their cycle
    initial begin
        forever begin
            @(negedge clk);
            while (!rst && sb_q.size() != 0 && sb_q[0].cyc == cyc) begin
                exp_t e;
                e = sb_q.pop_front();
                check(err_out == e.val, e.tag, int'(err_out), int'(e.val));
            end
        end
    end

    task automatic start_case(input logic [2:0] en_m, input logic [2:0] hold_m);
        rst = 1'b1;
        sb_q.delete();
        en = en_m;
        hold = hold_m;
        repeat (3) @(negedge clk);
        check(err_out == 1'b0, "R1 in reset", int'(err_out), 0);
        rst = 1'b0;
        expect_at(1, 1'b0, "R1 after reset");
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        // R2: all three alive
        start_case(3'b111, 3'b000);
        expect_at(100, 1'b0, "R2 all alive");
        expect_at(300, 1'b0, "R2 all alive");
        expect_at(600, 1'b0, "R2 all alive");
        drain();

        // R3/R4: processor 0 silent from reset
        start_case(3'b110, 3'b000);
        expect_at(SIL + SINGLE, 1'b0, "R4 one down, edge before trip");
        expect_at(SIL + SINGLE + 1, 1'b1, "R4 one down trip");
        drain();
        // R8: strokes resume, error stays
        en = 3'b111;
        expect_at(SIL + SINGLE + 80, 1'b1, "R8 sticky after resume");
        drain();

        // R5: two silent
        start_case(3'b100, 3'b000);
        expect_at(SIL + MULTI, 1'b0, "R5 two down, edge before trip");
        expect_at(SIL + MULTI + 1, 1'b1, "R5 two down trip");
        drain();

        // R5: all silent
        start_case(3'b000, 3'b000);
        expect_at(SIL + MULTI, 1'b0, "R5 three down, edge before trip");
        expect_at(SIL + MULTI + 1, 1'b1, "R5 three down trip");
        drain();

        // R6: one down, then a second stops
        start_case(3'b110, 3'b000);
        wait_cyc(60);
        en = 3'b100;
        expect_at(100, 1'b0, "R6 before short limit");
        expect_at(130, 1'b1, "R6 escalated trip");
        drain();

        // R7: the silent processor recovers in time
        start_case(3'b110, 3'b000);
        wait_cyc(100);
        en = 3'b111;
        expect_at(250, 1'b0, "R7 recovered");
        expect_at(600, 1'b0, "R7 recovered");
        drain();

        // R9: line 0 held high (single edge after reset only)
        start_case(3'b110, 3'b001);
        expect_at(SIL + SINGLE + 3, 1'b0, "R9 held high, edge before trip");
        expect_at(SIL + SINGLE + 4, 1'b1, "R9 held high trip");
        drain();

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end
endmodule